// File: doc/BRIEF.md
# Receive-Mode Power-Up Sequencer

This block brings a radio transceiver out of standby and into receive mode once software raises a receive-enable control bit. No other software action is needed after that. It walks a fixed series of power-up steps. Each step turns on one enable, or issues one calibration request, toward an analog or calibration function that lies outside the block. Some steps wait on a programmable timer and some wait on a done handshake before the next step begins.

The steps run in this order:

1. Regulators on.
2. Crystal oscillator on, followed by a timed start-up wait.
3. PLL on.
4. Optional VCO calibration, which uses a request/done handshake.
5. Timed PLL settle wait.
6. Receive front end on.
7. ADC (RC) calibration, which uses a request/acknowledge handshake.
8. Modem receive mode on.

All timed waits count ticks of a fixed prescaler, so each tick lasts `PRESCALE` clock cycles. The settle length comes from a 5-bit coarse field and a 3-bit fine field. In the software register that holds them, the coarse field occupies bits 7:3 and the fine field bits 2:0, with reset value 45h (coarse 8, fine 5). A VCO enable bit that resets to 1 selects whether the VCO calibration step runs. A half-start bit halves the crystal wait.

Dropping the receive-enable bit aborts the sequence at any step and returns the block to standby.

Top module: `rxseq_top`

## Requirements
- R1: After synchronous reset all step enables, both calibration requests, `busy`, `rx_ready` and `adc_cal_done` are 0.
- R2: With the block in standby, a cycle in which `rx_en` is 1 makes `ldo_en` and `busy` 1 from the next cycle on. `xosc_en` is still 0 in that cycle.
- R3: Steps come on in the order `ldo_en`, `xosc_en`, `pll_en`, `vco_cal_req` (when enabled), `rxfe_en`, `adc_cal_req`, `modem_rx_en`. Once on, `ldo_en`, `xosc_en`, `pll_en` and `rxfe_en` stay on until an abort.
- R4: `pll_en` rises exactly `XTAL_TICKS * PRESCALE` cycles after `xosc_en` rises when `xosc_half` is 0.
- R5: With `xosc_half` = 1 that interval is `max(1, XTAL_TICKS/2) * PRESCALE` cycles (integer halving).
- R6: With `vco_cal_en` = 1, `vco_cal_req` rises one cycle after `pll_en`. It stays high until the cycle after `vco_cal_done` is sampled high. At most one of `vco_cal_req` and `adc_cal_req` is high at any time.
- R7: With `vco_cal_en` = 0, `vco_cal_req` never rises and the settle wait starts the cycle after `pll_en` rises.
- R8: The settle wait is `max(1, settle_coarse*4 + settle_fine) * PRESCALE` cycles. It is measured from the fall of `vco_cal_req` to the rise of `rxfe_en`, or from the rise of `pll_en` plus one cycle when the VCO step is skipped.
- R9: `adc_cal_req` stays high until `adc_cal_ack` is sampled high. `adc_cal_done` is set when that handshake ends and is cleared when a new sequence starts.
- R10: On entry to receive mode, `modem_rx_en` goes to 1, `busy` goes to 0, and `rx_ready` is high for exactly one cycle.
- R11: A cycle in which `rx_en` is 0 drives every step enable, both requests and `busy` to 0 from the next cycle on, whatever the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive-enable control bit |
| xosc_half | input | 1 | Halve crystal start-up wait |
| vco_cal_en | input | 1 | Run VCO calibration step (reset value of the bit is 1) |
| settle_coarse | input | 5 | PLL settle coarse field (x4 ticks) |
| settle_fine | input | 3 | PLL settle fine field (ticks) |
| vco_cal_done | input | 1 | VCO calibration finished |
| adc_cal_ack | input | 1 | ADC calibration finished |
| ldo_en | output | 1 | Regulators enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| vco_cal_req | output | 1 | VCO calibration request |
| rxfe_en | output | 1 | Receive front end enable |
| adc_cal_req | output | 1 | ADC calibration request |
| modem_rx_en | output | 1 | Modem receive mode enable |
| busy | output | 1 | Sequence in progress |
| rx_ready | output | 1 | One-cycle pulse on entry to receive mode |
| adc_cal_done | output | 1 | ADC calibration complete status |

## Verification
The hardest conditions to reach from the ports are an abort that lands in the middle of a handshake step and a restart that follows a completed run. In the first, a calibration request is up and its done response is still pending when `rx_en` drops. In the second, the status bit must be seen cleared. The bench places a delayed responder on both calibration handshakes and times each `rx_en` drop to the cycle in which a chosen step output is first seen high. It then starts new sequences straight after completed ones. Timer lengths are checked as exact cycle distances between step edges, for the minimum, reset-value and maximum settle settings.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REG,
        ST_XOSC,
        ST_PLL,
        ST_VCO,
        ST_SETTLE,
        ST_FE,
        ST_ADC,
        ST_RX
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic adc_fin;
        logic tmr_load;
        logic tmr_clr;
    } seq_evt_t;

    typedef struct packed {
        logic modem;
        logic adc_req;
        logic fe;
        logic vco_req;
        logic pll;
        logic xosc;
        logic ldo;
    } step_out_t;

    // settle length in prescaled ticks, never zero
    function automatic int unsigned settle_ticks(input logic [4:0] coarse,
                                                 input logic [2:0] fine);
        int unsigned v;
        v = int'(coarse) * 4 + int'(fine);
        return (v == 0) ? 1 : v;
    endfunction

    // crystal wait in prescaled ticks, optionally halved, never zero
    function automatic int unsigned xosc_ticks(input int unsigned base,
                                               input logic half);
        int unsigned v;
        v = half ? (base >> 1) : base;
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/rxseq_tick_timer.sv
module rxseq_tick_timer #(
    parameter int PRESCALE = 4,
    parameter int TICK_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    output logic              done
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

    logic [PW-1:0]     presc;
    logic [TICK_W-1:0] cnt;
    logic              running;
    logic              tick;

    assign tick = running && (presc == PMAX);
    assign done = tick && (cnt == TICK_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            running <= 1'b0;
            presc   <= '0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            presc   <= '0;
            cnt     <= load_val;
        end else if (running) begin
            presc <= tick ? '0 : presc + PW'(1);
            if (tick) begin
                if (cnt == TICK_W'(1)) running <= 1'b0;
                cnt <= cnt - TICK_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
    import rxseq_pkg::*;
#(
    parameter int XTAL_TICKS = 12,
    parameter int TICK_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              xosc_half,
    input  logic              vco_cal_en,
    input  logic [4:0]        settle_coarse,
    input  logic [2:0]        settle_fine,
    input  logic              vco_cal_done,
    input  logic              adc_cal_ack,
    input  logic              tmr_done,
    output seq_state_t        state,
    output seq_evt_t          evt,
    output logic [TICK_W-1:0] load_val
);
    seq_state_t nx;

    always_comb begin
        nx       = state;
        evt      = '0;
        load_val = '0;
        if (!rx_en) begin
            nx          = ST_IDLE;
            evt.tmr_clr = 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    nx        = ST_REG;
                    evt.start = 1'b1;
                end
                ST_REG: begin
                    nx           = ST_XOSC;
                    evt.tmr_load = 1'b1;
                    load_val     = TICK_W'(xosc_ticks(XTAL_TICKS, xosc_half));
                end
                ST_XOSC: if (tmr_done) nx = ST_PLL;
                ST_PLL: begin
                    if (vco_cal_en) begin
                        nx = ST_VCO;
                    end else begin
                        nx           = ST_SETTLE;
                        evt.tmr_load = 1'b1;
                        load_val     = TICK_W'(settle_ticks(settle_coarse, settle_fine));
                    end
                end
                ST_VCO: begin
                    if (vco_cal_done) begin
                        nx           = ST_SETTLE;
                        evt.tmr_load = 1'b1;
                        load_val     = TICK_W'(settle_ticks(settle_coarse, settle_fine));
                    end
                end
                ST_SETTLE: if (tmr_done) nx = ST_FE;
                ST_FE:     nx = ST_ADC;
                ST_ADC: begin
                    if (adc_cal_ack) begin
                        nx          = ST_RX;
                        evt.adc_fin = 1'b1;
                    end
                end
                ST_RX:   nx = ST_RX;
                default: nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nx;
    end
endmodule

// File: rtl/rxseq_outdec.sv
module rxseq_outdec
    import rxseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t state,
    input  seq_evt_t   evt,
    output step_out_t  steps,
    output logic       busy,
    output logic       rx_ready,
    output logic       adc_cal_done
);
    always_comb begin
        steps.ldo     = (state != ST_IDLE);
        steps.xosc    = (state >= ST_XOSC);
        steps.pll     = (state >= ST_PLL);
        steps.vco_req = (state == ST_VCO);
        steps.fe      = (state >= ST_FE);
        steps.adc_req = (state == ST_ADC);
        steps.modem   = (state == ST_RX);
        busy          = (state != ST_IDLE) && (state != ST_RX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ready     <= 1'b0;
            adc_cal_done <= 1'b0;
        end else begin
            rx_ready <= evt.adc_fin;
            if (evt.start)        adc_cal_done <= 1'b0;
            else if (evt.adc_fin) adc_cal_done <= 1'b1;
        end
    end
endmodule

// File: rtl/rxseq_top.sv
module rxseq_top
    import rxseq_pkg::*;
#(
    parameter int PRESCALE   = 4,
    parameter int XTAL_TICKS = 12,
    parameter int TICK_W     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       xosc_half,
    input  logic       vco_cal_en,
    input  logic [4:0] settle_coarse,
    input  logic [2:0] settle_fine,
    input  logic       vco_cal_done,
    input  logic       adc_cal_ack,
    output logic       ldo_en,
    output logic       xosc_en,
    output logic       pll_en,
    output logic       vco_cal_req,
    output logic       rxfe_en,
    output logic       adc_cal_req,
    output logic       modem_rx_en,
    output logic       busy,
    output logic       rx_ready,
    output logic       adc_cal_done
);
    seq_state_t        state;
    seq_evt_t          evt;
    step_out_t         steps;
    logic [TICK_W-1:0] load_val;
    logic              tmr_done;

    rxseq_fsm #(.XTAL_TICKS(XTAL_TICKS), .TICK_W(TICK_W)) u_fsm (
        .clk(clk), .rst(rst), .rx_en(rx_en), .xosc_half(xosc_half),
        .vco_cal_en(vco_cal_en), .settle_coarse(settle_coarse),
        .settle_fine(settle_fine), .vco_cal_done(vco_cal_done),
        .adc_cal_ack(adc_cal_ack), .tmr_done(tmr_done),
        .state(state), .evt(evt), .load_val(load_val)
    );

    rxseq_tick_timer #(.PRESCALE(PRESCALE), .TICK_W(TICK_W)) u_tmr (
        .clk(clk), .rst(rst), .clr(evt.tmr_clr), .load(evt.tmr_load),
        .load_val(load_val), .done(tmr_done)
    );

    rxseq_outdec u_dec (
        .clk(clk), .rst(rst), .state(state), .evt(evt), .steps(steps),
        .busy(busy), .rx_ready(rx_ready), .adc_cal_done(adc_cal_done)
    );

    assign ldo_en      = steps.ldo;
    assign xosc_en     = steps.xosc;
    assign pll_en      = steps.pll;
    assign vco_cal_req = steps.vco_req;
    assign rxfe_en     = steps.fe;
    assign adc_cal_req = steps.adc_req;
    assign modem_rx_en = steps.modem;
endmodule

// File: rtl/rxseq_chk.sv
module rxseq_chk (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic vco_cal_done,
    input logic adc_cal_ack,
    input logic ldo_en,
    input logic xosc_en,
    input logic pll_en,
    input logic vco_cal_req,
    input logic rxfe_en,
    input logic adc_cal_req,
    input logic modem_rx_en,
    input logic busy,
    input logic rx_ready,
    input logic adc_cal_done
);
    AST_START_STEP: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !ldo_en) |=> (ldo_en && busy && !xosc_en)); // R2

    AST_ORDER_FE: assert property (@(posedge clk) disable iff (rst)
        rxfe_en |-> (pll_en && xosc_en && ldo_en)); // R3

    AST_ORDER_MODEM: assert property (@(posedge clk) disable iff (rst)
        modem_rx_en |-> (rxfe_en && !adc_cal_req && !vco_cal_req)); // R3

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vco_cal_req, adc_cal_req})); // R6

    AST_VCO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (vco_cal_req && !vco_cal_done && rx_en) |=> vco_cal_req); // R6

    AST_ADC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (adc_cal_req && !adc_cal_ack && rx_en) |=> adc_cal_req); // R9

    AST_ADC_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
        (ldo_en && !xosc_en) |-> !adc_cal_done); // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready); // R10

    AST_READY_STATE: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> (modem_rx_en && !busy && adc_cal_done)); // R10

    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!ldo_en && !busy && !vco_cal_req && !adc_cal_req && !modem_rx_en)); // R11
endmodule

bind rxseq_top rxseq_chk u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .vco_cal_done(vco_cal_done),
    .adc_cal_ack(adc_cal_ack), .ldo_en(ldo_en), .xosc_en(xosc_en),
    .pll_en(pll_en), .vco_cal_req(vco_cal_req), .rxfe_en(rxfe_en),
    .adc_cal_req(adc_cal_req), .modem_rx_en(modem_rx_en), .busy(busy),
    .rx_ready(rx_ready), .adc_cal_done(adc_cal_done)
);

// File: tb/sim_rxseq_top.sv
module sim_rxseq_top;
    localparam int P    = 4;
    localparam int XT   = 12;
    localparam int VDLY = 3;
    localparam int ADLY = 5;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0, xosc_half = 1'b0, vco_cal_en = 1'b1;
    logic [4:0] settle_coarse = 5'd8;
    logic [2:0] settle_fine = 3'd5;
    logic vco_cal_done = 1'b0, adc_cal_ack = 1'b0;
    logic ldo_en, xosc_en, pll_en, vco_cal_req, rxfe_en, adc_cal_req, modem_rx_en;
    logic busy, rx_ready, adc_cal_done;

    int vectors = 0, fails = 0, cyc = 0;
    int rise_at[7], fall_at[7];
    int ready_cnt = 0, vcnt = 0, acnt = 0;
    logic [6:0] prev = '0;
    logic [6:0] outs;

    always #10 clk = ~clk;

    rxseq_top #(.PRESCALE(P), .XTAL_TICKS(XT), .TICK_W(8)) u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .xosc_half(xosc_half),
        .vco_cal_en(vco_cal_en), .settle_coarse(settle_coarse),
        .settle_fine(settle_fine), .vco_cal_done(vco_cal_done),
        .adc_cal_ack(adc_cal_ack), .ldo_en(ldo_en), .xosc_en(xosc_en),
        .pll_en(pll_en), .vco_cal_req(vco_cal_req), .rxfe_en(rxfe_en),
        .adc_cal_req(adc_cal_req), .modem_rx_en(modem_rx_en), .busy(busy),
        .rx_ready(rx_ready), .adc_cal_done(adc_cal_done)
    );

    // index: 0 ldo, 1 xosc, 2 pll, 3 vco_req, 4 fe, 5 adc_req, 6 modem
    assign outs = {modem_rx_en, adc_cal_req, rxfe_en, vco_cal_req, pll_en, xosc_en, ldo_en};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // edge monitor and calibration responders
    always @(negedge clk) begin
        for (int i = 0; i < 7; i++) begin
            if (outs[i] && !prev[i]) rise_at[i] = cyc;
            if (!outs[i] && prev[i]) fall_at[i] = cyc;
        end
        prev = outs;
        if (rx_ready) ready_cnt = ready_cnt + 1;
        if (vco_cal_req) begin vcnt = vcnt + 1; vco_cal_done = (vcnt == VDLY); end
        else begin vcnt = 0; vco_cal_done = 1'b0; end
        if (adc_cal_req) begin acnt = acnt + 1; adc_cal_ack = (acnt == ADLY); end
        else begin acnt = 0; adc_cal_ack = 1'b0; end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors = vectors + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clear_marks();
        for (int i = 0; i < 7; i++) begin rise_at[i] = -1; fall_at[i] = -1; end
        ready_cnt = 0;
    endtask

    task automatic wait_high(input int idx, input int limit);
        int n = 0;
        while (!outs[idx] && n < limit) begin @(negedge clk); n++; end
        if (!outs[idx]) chk("wait timeout", 0, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 outputs", int'({outs, busy, rx_ready, adc_cal_done}), 0);
    endtask

    task automatic t_run(input logic half, input logic ven,
                         input logic [4:0] co, input logic [2:0] fi);
        int xt, st;
        xt = half ? XT / 2 : XT;
        if (xt == 0) xt = 1;
        st = int'(co) * 4 + int'(fi);
        if (st == 0) st = 1;
        xosc_half = half; vco_cal_en = ven; settle_coarse = co; settle_fine = fi;
        clear_marks();
        @(negedge clk); rx_en = 1'b1;
        @(negedge clk);
        chk("R2 ldo", int'(ldo_en), 1);
        chk("R2 busy", int'(busy), 1);
        chk("R2 xosc low", int'(xosc_en), 0);
        chk("R9 status cleared on start", int'(adc_cal_done), 0);
        wait_high(6, 3000);
        @(negedge clk); @(negedge clk);
        chk("R3 order", int'(rise_at[0] < rise_at[1] && rise_at[1] < rise_at[2]
            && rise_at[2] < rise_at[4] && rise_at[4] < rise_at[5]
            && rise_at[5] < rise_at[6]), 1);
        chk("R3 held", int'(ldo_en && xosc_en && pll_en && rxfe_en), 1);
        if (half) chk("R5 half xtal wait", rise_at[2] - rise_at[1], xt * P);
        else      chk("R4 xtal wait", rise_at[2] - rise_at[1], xt * P);
        if (ven) begin
            chk("R6 vco start", rise_at[3] - rise_at[2], 1);
            chk("R6 vco hold", fall_at[3] - rise_at[3], VDLY);
            chk("R8 settle", rise_at[4] - fall_at[3], st * P);
        end else begin
            chk("R7 vco skipped", rise_at[3], -1);
            chk("R8 settle skip", rise_at[4] - rise_at[2], st * P + 1);
        end
        chk("R9 adc hold", fall_at[5] - rise_at[5], ADLY);
        chk("R9 status set", int'(adc_cal_done), 1);
        chk("R10 ready pulses", ready_cnt, 1);
        chk("R10 busy low", int'(busy), 0);
        chk("R10 modem", int'(modem_rx_en), 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R11 drop from rx", int'({outs, busy}), 0);
    endtask

    task automatic t_abort(input int idx);
        xosc_half = 1'b0; vco_cal_en = 1'b1; settle_coarse = 5'd1; settle_fine = 3'd2;
        clear_marks();
        @(negedge clk); rx_en = 1'b1;
        @(negedge clk);
        wait_high(idx, 3000);
        rx_en = 1'b0;
        @(negedge clk);
        chk($sformatf("R11 abort at step %0d", idx), int'({outs, busy}), 0);
        repeat (3) @(negedge clk);
        chk("R11 stays idle", int'({outs, busy}), 0);
    endtask

    initial begin
        clear_marks();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run(1'b0, 1'b1, 5'd8, 3'd5);
        t_run(1'b1, 1'b0, 5'd0, 3'd0);
        t_abort(1);
        t_abort(3);
        t_abort(5);
        t_run(1'b1, 1'b1, 5'd31, 3'd7);
        t_abort(6);
        t_run(1'b0, 1'b0, 5'd2, 3'd3);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule